// File: doc/BRIEF.md
# Parallel-Load Serial Shifter with Clock Inhibit

The shifter accepts a word on parallel inputs and sends it out one bit at a time from a single serial output. Holding the active-low load input low puts the parallel word into the register. This does not need a clock edge: while load stays low, every change on the parallel inputs is copied into the register straight away.

With load high, each rising clock edge moves the contents one stage toward the output, but only while the hold input is low. The first stage takes its new bit from a serial input. That input lets the block work as a plain serial-in/serial-out delay line, or lets several of them be chained. In the register the hold input works as a clock enable; it does not gate the clock.

Top module: `piso_shifter`

## Requirements
- R1: While `ld_n` is low, stage i of the register equals `par_in[i]`. This holds with no clock edge, and a change on `par_in` during the load is taken in straight away.
- R2: While `ld_n` is low, rising clock edges do not shift. When `ld_n` returns high, the register holds the last value on `par_in`.
- R3: On a rising clock edge with `ld_n` high and `hold` low, stage i takes the old stage i-1 for i from 1 to WIDTH-1. Stage 0 takes `ser_in`.
- R4: On a rising clock edge with `ld_n` high and `hold` high, every stage keeps its value.
- R5: `ser_out` always shows stage WIDTH-1. Right after a load and before any shift, it therefore shows `par_in[WIDTH-1]`.
- R6: After a load, enabled shifts present the loaded bits on `ser_out` from `par_in[WIDTH-1]` down to `par_in[0]`. After WIDTH enabled shifts, none of the loaded bits is left in the register.
- R7: A bit applied on `ser_in` at an enabled edge appears on `ser_out` after exactly WIDTH enabled edges. Edges with `hold` high do not count toward that total.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock, rising edge |
| ld_n | input | 1 | Active-low level load of the parallel word (asynchronous) |
| hold | input | 1 | High suppresses shifting (clock enable, active low) |
| ser_in | input | 1 | Serial bit fed into stage 0 |
| par_in | input | WIDTH | Parallel word; bit i goes to stage i |
| ser_out | output | 1 | Last stage of the register |

## Verification
The hardest case to reach from the ports is the asynchronous load. The parallel word changes while load is low, with no clock edge in between. The bench changes `par_in` twice inside one clock phase and checks `ser_out` a nanosecond after each change. It then keeps load low across a rising edge and shifts the whole word out, which shows that nothing was shifted during the load. Random traffic mixes hold pulses into the shifting and checks every output bit against a model kept in the bench.

// File: rtl/piso_shifter.sv
module piso_shifter #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             ld_n,
  input  logic             hold,
  input  logic             ser_in,
  input  logic [WIDTH-1:0] par_in,
  output logic             ser_out
);

  localparam int LAST = WIDTH - 1;

  logic [WIDTH-1:0] stage;
  logic [WIDTH-1:0] nxt;
  logic [WIDTH-1:0] pre;
  logic [WIDTH-1:0] clr;
  logic             shift_en;

  assign shift_en = ld_n & ~hold;
  assign nxt      = {stage[LAST-1:0], ser_in};
  assign pre      = {WIDTH{~ld_n}} & par_in;
  assign clr      = {WIDTH{~ld_n}} & ~par_in;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic q;
    always_ff @(posedge clk or posedge pre[i] or posedge clr[i]) begin
      if (clr[i])        q <= 1'b0;
      else if (pre[i])   q <= 1'b1;
      else if (shift_en) q <= nxt[i];
    end
    assign stage[i] = q;
  end

  assign ser_out = stage[LAST];

endmodule

// File: rtl/piso_shifter_chk.sv
module piso_shifter_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             ld_n,
  input logic             hold,
  input logic             ser_in,
  input logic [WIDTH-1:0] par_in,
  input logic [WIDTH-1:0] stage,
  input logic             ser_out
);

  logic primed = 1'b0;
  always_ff @(posedge clk) if (!ld_n) primed <= 1'b1;

  a_r1_load_follows: assert property (@(posedge clk)
    !ld_n |-> stage == par_in);

  a_r2_no_shift_in_load: assert property (@(posedge clk) disable iff (!primed)
    (ld_n && $past(!ld_n)) |-> stage == $past(par_in));

  a_r3_shift_step: assert property (@(posedge clk) disable iff (!primed)
    (ld_n && $past(ld_n) && !$past(hold)) |->
      stage == {$past(stage[WIDTH-2:0]), $past(ser_in)});

  a_r4_hold_stable: assert property (@(posedge clk) disable iff (!primed)
    (ld_n && $past(ld_n) && $past(hold)) |-> $stable(stage));

  a_r5_out_after_shift: assert property (@(posedge clk) disable iff (!primed)
    (ld_n && $past(ld_n) && !$past(hold)) |-> ser_out == $past(stage[WIDTH-2]));

endmodule

bind piso_shifter piso_shifter_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .ld_n(ld_n), .hold(hold), .ser_in(ser_in),
  .par_in(par_in), .stage(stage), .ser_out(ser_out)
);

// File: tb/piso_shifter_tb.sv
module piso_shifter_tb;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         ld_n = 1'b1;
  logic         hold = 1'b1;
  logic         ser_in = 1'b0;
  logic [W-1:0] par_in = '0;
  logic         ser_out;

  int n_chk = 0;
  int n_bad = 0;
  logic [W-1:0] model;

  always #5 clk = ~clk;

  piso_shifter #(.WIDTH(W)) u_dut (
    .clk(clk), .ld_n(ld_n), .hold(hold), .ser_in(ser_in),
    .par_in(par_in), .ser_out(ser_out)
  );

  function automatic logic [W-1:0] step(logic [W-1:0] s, logic si);
    return {s[W-2:0], si};
  endfunction

  task automatic check(string req, logic exp);
    n_chk++;
    if (ser_out !== exp) begin
      n_bad++;
      $display("FAIL %s: ser_out=%b expected=%b at %0t", req, ser_out, exp, $time);
    end
  endtask

  // load across one rising edge; entered and left at a falling edge
  task automatic load(logic [W-1:0] w);
    ld_n = 1'b0; par_in = w; model = w;
    #1 check("R1", w[W-1]);
    @(negedge clk);
    check("R2", w[W-1]);
    ld_n = 1'b1;
    #1 check("R5", w[W-1]);
  endtask

  task automatic clock(logic h, logic si);
    hold = h; ser_in = si;
    @(negedge clk);
    if (!h) model = step(model, si);
    check(h ? "R4" : "R3", model[W-1]);
  endtask

  initial begin
    logic [W-1:0] a, b, w;
    void'($urandom(32'd2024));
    @(negedge clk);

    // R1: asynchronous follow inside one clock phase, then R2 over an edge
    a = 8'hA5; b = 8'h3C;
    ld_n = 1'b0; par_in = a;
    #1 check("R1", a[W-1]);
    par_in = b;
    #1 check("R1", b[W-1]);
    par_in = a ^ 8'h80;
    #1 check("R1", ~a[W-1]);
    par_in = b; model = b;
    @(negedge clk);
    check("R2", b[W-1]);
    ld_n = 1'b1;
    // R6: bit order of the loaded word
    for (int i = W - 1; i >= 0; i--) begin
      #1 check("R6", b[i]);
      clock(1'b0, 1'b0);
    end
    check("R6", 1'b0);

    // R4: hold keeps the word
    load(8'h81);
    for (int i = 0; i < 5; i++) clock(1'b1, 1'b1);
    check("R4", 1'b1);

    // R7: serial in to serial out after W enabled edges, holds interleaved
    load(8'h00);
    clock(1'b0, 1'b1);
    for (int i = 1; i < W; i++) begin
      clock(1'b1, 1'b0);
      clock(1'b0, 1'b0);
    end
    check("R7", 1'b1);

    // random loads and shifts with hold pulses
    for (int k = 0; k < 60; k++) begin
      w = W'($urandom);
      load(w);
      for (int j = 0; j < 12; j++)
        clock(($urandom % 4) == 0, 1'($urandom));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule